// File: doc/BRIEF.md
# Instruction Address Generator

This block keeps the program counter of a five-step multicycle RISC core, together with a return-address holding register, and forms every instruction address the core uses. The step sequencer drives a set of strobes each step: a PC write enable, an increment request, a branch request with its equality flag, a load-from-register request, and a capture request for the return register. The block also takes a sign-extended byte offset from the instruction and the first register operand.

In the fetch step the sequencer asks for an increment, so the PC moves on by four bytes. In a conditional-branch step the block adds the offset to the already-advanced PC, but only when the compare flag reports equality. In a register-indirect call step the old PC is copied into the return register while the PC is loaded from the register operand. The return register output feeds the writeback multiplexer one step later. A subroutine return is a plain load of the PC from the register operand.

Top module: `iag_unit`

## Requirements
- R1: A synchronous active-high reset sets `pc_o` and `link_o` to 0 at the next rising clock edge.
- R2: While `pc_wr_en` is 0, `pc_o` keeps its value at the clock edge, whatever the other PC strobes are.
- R3: With `pc_wr_en`=1 and `inc_req`=1, and no load or taken branch requested, `pc_o` becomes `pc_o`+4 modulo 2^32. 0xFFFFFFFC wraps to 0x00000000.
- R4: With `pc_wr_en`=1, `br_req`=1, `br_equal`=1 and no load requested, `pc_o` becomes `pc_o`+`br_offset` modulo 2^32. The offset is a two's-complement byte count, so negative offsets move the PC backwards.
- R5: If `br_req`=1 and `br_equal`=0, the branch is not taken. `pc_o` then holds when `inc_req`=0 and increments when `inc_req`=1.
- R6: With `pc_wr_en`=1 and `ld_reg`=1, `pc_o` becomes the value of `reg_a` sampled at that edge. This serves both call and return.
- R7: Priority when requests coincide: a load from `reg_a` wins over a taken branch, and a taken branch wins over an increment.
- R8: When `save_ret`=1, `link_o` takes the value `pc_o` had before that edge, even if the PC is rewritten at the same edge. This does not depend on `pc_wr_en`.
- R9: When `save_ret`=0, `link_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr_en | input | 1 | Allows the PC to be written this step |
| inc_req | input | 1 | Request sequential advance by 4 |
| br_req | input | 1 | Conditional-branch step |
| br_equal | input | 1 | Compared operands were equal |
| ld_reg | input | 1 | Load the PC from the register operand |
| save_ret | input | 1 | Capture the current PC into the return register |
| br_offset | input | 32 | Sign-extended byte offset |
| reg_a | input | 32 | Register operand used for call and return targets |
| pc_o | output | 32 | Current program counter |
| link_o | output | 32 | Saved return address for writeback |

## Verification
The case most likely to break is the call step. There the return register captures the PC at the same edge that the PC is overwritten from `reg_a`, so the captured value must be the old PC and not the new one. The bench drives `save_ret` and `ld_reg` together after the PC has been moved to a known value, then checks both outputs after that one edge. The bench also raises increment, taken branch and register load in overlapping combinations, and compares the PC against the value the priority order predicts.

// File: rtl/iag_pkg.sv
package iag_pkg;
   typedef enum logic [1:0] {
      NXT_HOLD   = 2'd0,
      NXT_SEQ    = 2'd1,
      NXT_BRANCH = 2'd2,
      NXT_REG    = 2'd3
   } nxt_sel_e;
endpackage

// File: rtl/iag_next_sel.sv
module iag_next_sel
   import iag_pkg::*;
(
   input  logic     wr_en,
   input  logic     inc,
   input  logic     br,
   input  logic     eq,
   input  logic     ld,
   output nxt_sel_e sel,
   output logic     use_off
);
   logic taken;
   assign taken   = br & eq;
   assign use_off = taken & ~ld;

   always_comb begin
      if (!wr_en)     sel = NXT_HOLD;
      else if (ld)    sel = NXT_REG;
      else if (taken) sel = NXT_BRANCH;
      else if (inc)   sel = NXT_SEQ;
      else            sel = NXT_HOLD;
   end
endmodule

// File: rtl/iag_adder.sv
module iag_adder #(
   parameter int unsigned W         = 32,
   parameter int unsigned STEP      = 4,
   parameter bit          SHARED    = 1'b1
) (
   input  logic [W-1:0] pc,
   input  logic [W-1:0] off,
   input  logic         use_off,
   output logic [W-1:0] seq_addr,
   output logic [W-1:0] br_addr
);
   localparam logic [W-1:0] STEP_V = W'(STEP);

   generate
      if (SHARED) begin : g_one_adder
         logic [W-1:0] operand;
         logic [W-1:0] sum;
         assign operand  = use_off ? off : STEP_V;
         assign sum      = pc + operand;
         assign seq_addr = sum;
         assign br_addr  = sum;
      end else begin : g_two_adders
         logic unused_sel;
         assign unused_sel = use_off;
         assign seq_addr   = pc + STEP_V;
         assign br_addr    = pc + off;
      end
   endgenerate
endmodule

// File: rtl/iag_ret_reg.sv
module iag_ret_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cap,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)      q <= '0;
      else if (cap) q <= d;
   end
endmodule

// File: rtl/iag_unit.sv
module iag_unit
   import iag_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned STEP_BYTES = 4,
   parameter bit          SHARED_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pc_wr_en,
   input  logic              inc_req,
   input  logic              br_req,
   input  logic              br_equal,
   input  logic              ld_reg,
   input  logic              save_ret,
   input  logic [ADDR_W-1:0] br_offset,
   input  logic [ADDR_W-1:0] reg_a,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] link_o
);
   localparam int unsigned STEP_LOG = $clog2(STEP_BYTES);

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("iag_unit: ADDR_W must be at least 8");
      end
      if ((STEP_BYTES == 0) || ((1 << STEP_LOG) != STEP_BYTES)) begin : g_bad_step
         $error("iag_unit: STEP_BYTES must be a power of two");
      end
   endgenerate

   nxt_sel_e          sel;
   logic              use_off;
   logic [ADDR_W-1:0] seq_addr;
   logic [ADDR_W-1:0] br_addr;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_d;

   iag_next_sel i_sel (
      .wr_en   (pc_wr_en),
      .inc     (inc_req),
      .br      (br_req),
      .eq      (br_equal),
      .ld      (ld_reg),
      .sel     (sel),
      .use_off (use_off)
   );

   iag_adder #(
      .W      (ADDR_W),
      .STEP   (STEP_BYTES),
      .SHARED (SHARED_ADD)
   ) i_add (
      .pc       (pc_q),
      .off      (br_offset),
      .use_off  (use_off),
      .seq_addr (seq_addr),
      .br_addr  (br_addr)
   );

   always_comb begin
      unique case (sel)
         NXT_SEQ:    pc_d = seq_addr;
         NXT_BRANCH: pc_d = br_addr;
         NXT_REG:    pc_d = reg_a;
         default:    pc_d = pc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_d;
   end

   iag_ret_reg #(.W(ADDR_W)) i_ret (
      .clk (clk),
      .rst (rst),
      .cap (save_ret),
      .d   (pc_q),
      .q   (link_o)
   );

   assign pc_o = pc_q;
endmodule

// File: rtl/iag_unit_chk.sv
module iag_unit_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned STEP_BYTES = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              pc_wr_en,
   input logic              inc_req,
   input logic              br_req,
   input logic              br_equal,
   input logic              ld_reg,
   input logic              save_ret,
   input logic [ADDR_W-1:0] br_offset,
   input logic [ADDR_W-1:0] reg_a,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] link_o
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP_BYTES);

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (pc_o == '0) && (link_o == '0));

   // R2
   pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !pc_wr_en |=> $stable(pc_o));

   // R3
   pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
      (pc_wr_en && inc_req && !ld_reg && !(br_req && br_equal))
      |=> pc_o == $past(pc_o) + STEP_V);

   // R4
   pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
      (pc_wr_en && br_req && br_equal && !ld_reg)
      |=> pc_o == $past(pc_o) + $past(br_offset));

   // R5
   branch_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (pc_wr_en && br_req && !br_equal && !inc_req && !ld_reg) |=> $stable(pc_o));

   // R6
   pc_load_chk: assert property (@(posedge clk) disable iff (rst)
      (pc_wr_en && ld_reg) |=> pc_o == $past(reg_a));

   // R8
   ret_capture_chk: assert property (@(posedge clk) disable iff (rst)
      save_ret |=> link_o == $past(pc_o));

   // R9
   ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !save_ret |=> $stable(link_o));
endmodule

bind iag_unit iag_unit_chk #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES)) i_iag_chk (
   .clk       (clk),
   .rst       (rst),
   .pc_wr_en  (pc_wr_en),
   .inc_req   (inc_req),
   .br_req    (br_req),
   .br_equal  (br_equal),
   .ld_reg    (ld_reg),
   .save_ret  (save_ret),
   .br_offset (br_offset),
   .reg_a     (reg_a),
   .pc_o      (pc_o),
   .link_o    (link_o)
);

// File: tb/test_iag_unit.sv
module test_iag_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pc_wr_en = 1'b0, inc_req = 1'b0, br_req = 1'b0;
   logic        br_equal = 1'b0, ld_reg = 1'b0, save_ret = 1'b0;
   logic [31:0] br_offset = '0, reg_a = '0;
   logic [31:0] pc_o, link_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   iag_unit i_iag_unit (
      .clk(clk), .rst(rst), .pc_wr_en(pc_wr_en), .inc_req(inc_req),
      .br_req(br_req), .br_equal(br_equal), .ld_reg(ld_reg),
      .save_ret(save_ret), .br_offset(br_offset), .reg_a(reg_a),
      .pc_o(pc_o), .link_o(link_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one edge with the given strobes, then strobes return to idle
   task automatic step(input logic wr, input logic inc, input logic br, input logic eq,
                       input logic ld, input logic sv, input logic [31:0] off,
                       input logic [31:0] ra);
      pc_wr_en = wr; inc_req = inc; br_req = br; br_equal = eq;
      ld_reg = ld; save_ret = sv; br_offset = off; reg_a = ra;
      @(posedge clk); #1;
      pc_wr_en = 0; inc_req = 0; br_req = 0; br_equal = 0;
      ld_reg = 0; save_ret = 0; br_offset = '0; reg_a = '0;
   endtask

   task automatic set_pc(input logic [31:0] v);
      step(1, 0, 0, 0, 1, 0, '0, v);
   endtask

   task automatic t_reset;
      rst = 1; @(posedge clk); #1; rst = 0;
      chk("R1 pc", pc_o, 32'h0);
      chk("R1 link", link_o, 32'h0);
   endtask

   task automatic t_increment;
      step(1, 1, 0, 0, 0, 0, '0, '0);
      chk("R3 first", pc_o, 32'h4);
      step(1, 1, 0, 0, 0, 0, '0, '0);
      chk("R3 second", pc_o, 32'h8);
      set_pc(32'hFFFF_FFFC);
      chk("R6 load", pc_o, 32'hFFFF_FFFC);
      step(1, 1, 0, 0, 0, 0, '0, '0);
      chk("R3 wrap", pc_o, 32'h0);
   endtask

   task automatic t_hold;
      set_pc(32'h0000_1000);
      step(0, 1, 1, 1, 1, 0, 32'h40, 32'hDEAD_BEEF);
      chk("R2 hold all strobes", pc_o, 32'h0000_1000);
   endtask

   task automatic t_branch;
      set_pc(32'h0000_2004);
      step(1, 0, 1, 1, 0, 0, 32'h0000_0100, '0);
      chk("R4 forward", pc_o, 32'h0000_2104);
      step(1, 0, 1, 1, 0, 0, 32'hFFFF_FF00, '0);
      chk("R4 backward", pc_o, 32'h0000_2004);
      step(1, 0, 1, 0, 0, 0, 32'h0000_0100, '0);
      chk("R5 not taken hold", pc_o, 32'h0000_2004);
      step(1, 1, 1, 0, 0, 0, 32'h0000_0100, '0);
      chk("R5 not taken inc", pc_o, 32'h0000_2008);
      set_pc(32'hFFFF_FFF0);
      step(1, 0, 1, 1, 0, 0, 32'h0000_0020, '0);
      chk("R4 wrap", pc_o, 32'h0000_0010);
   endtask

   task automatic t_priority;
      set_pc(32'h0000_3000);
      step(1, 1, 1, 1, 0, 0, 32'h0000_0040, '0);
      chk("R7 branch over inc", pc_o, 32'h0000_3040);
      step(1, 1, 1, 1, 1, 0, 32'h0000_0040, 32'h0000_8888);
      chk("R7 load over branch", pc_o, 32'h0000_8888);
      step(1, 1, 0, 0, 1, 0, '0, 32'h0000_0A00);
      chk("R7 load over inc", pc_o, 32'h0000_0A00);
   endtask

   task automatic t_call_return;
      set_pc(32'h0000_0504);
      step(1, 0, 0, 0, 1, 1, '0, 32'h0000_7000);
      chk("R8 call pc", pc_o, 32'h0000_7000);
      chk("R8 call link old pc", link_o, 32'h0000_0504);
      step(1, 1, 0, 0, 0, 0, '0, '0);
      chk("R9 link held", link_o, 32'h0000_0504);
      step(1, 0, 0, 0, 1, 0, '0, 32'h0000_0504);
      chk("R6 return", pc_o, 32'h0000_0504);
      chk("R9 link held on return", link_o, 32'h0000_0504);
      step(0, 0, 0, 0, 0, 1, '0, '0);
      chk("R8 capture without wr_en", link_o, 32'h0000_0504);
      set_pc(32'h0000_0C00);
      step(0, 0, 0, 0, 0, 1, '0, '0);
      chk("R8 capture new", link_o, 32'h0000_0C00);
      t_reset();
   endtask

   initial begin
      #1;
      @(posedge clk); #1;
      t_reset();
      t_increment();
      t_hold();
      t_branch();
      t_priority();
      t_call_return();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule